// File: doc/BRIEF.md
# Read-Latency Enable Delay Generator

This block takes the per-cycle read-data enable that the core raises once for every word it expects back from an external device, and produces two delayed copies of it. The earlier copy opens the strobe gate of the capture path; the later copy is the read enable of the capture FIFO. The later copy is also the data-valid flag to the core, and both leave the block in the same cycle.

Each copy comes from its own shift register with a selectable tap. The default taps are derived from the `RD_LAT` parameter. With these defaults, the valid flag trails the enable by `RD_LAT` cycles and the strobe gate opens one cycle earlier. This models a strobe path with no extra output delay.

A small register write port can reprogram either tap at run time. A write is held as pending. It is moved into the active tap only on a cycle when no enable is in flight, so a burst in progress is never split across two latencies. The configuration controller is a two-state machine:
- `CF_RUN`: active taps equal the last applied values.
- `CF_WAIT`: a write is pending.

Its transitions are:
- `RUN->WAIT`: on any write.
- `WAIT->WAIT`: on a further write, or while the pipeline is busy.
- `WAIT->RUN`: on the first quiet cycle with no write. The pending values are applied on that edge.

Top module: `rden_delay_gen`

## Requirements
- R1: Out of reset, `stb_gate_en`, `fifo_rd_en` and `rd_valid` are low. The read tap holds `RD_LAT-1` and the strobe tap holds `RD_LAT-2`.
- R2: `fifo_rd_en` and `rd_valid` are high in exactly the same cycles.
- R3: With default settings, an enable sampled at clock edge k raises `rd_valid` for one cycle after edge k+`RD_LAT`.
- R4: With default settings, the strobe enable for that input rises one cycle before `rd_valid`, after edge k+`RD_LAT`-1. It never carries more pulses than were input.
- R5: A tap value d delays by d+1 cycles. The value 0 gives a single register stage.
- R6: `cfg_sel`=0 addresses the strobe tap and `cfg_sel`=1 addresses the read tap. A write changes only the addressed tap.
- R7: A written value takes effect only on an edge where both shift registers are empty, `rd_en_in` is low and no write is present. Enables issued before that edge keep the old delay.
- R8: A burst of N consecutive enables yields N consecutive output cycles on each path, with no pulse lost or duplicated.
- R9: Tap values up to `DEPTH-1` (31 by default) are honoured. Larger values are clamped to `DEPTH-1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en_in | input | 1 | Read-data enable from the core, one cycle per expected word |
| cfg_we | input | 1 | Write strobe for the tap registers |
| cfg_sel | input | 1 | Tap select: 0 strobe, 1 read |
| cfg_val | input | $clog2(DEPTH) (5) | New tap value |
| stb_gate_en | output | 1 | Delayed enable for the strobe gate |
| fifo_rd_en | output | 1 | Delayed read enable for the capture FIFO |
| rd_valid | output | 1 | Data-valid flag to the core |

## Verification
The properties assume that `rd_en_in` and the write port are clean synchronous levels and are held low during reset. They also assume that the enable count stays well below the range of the checker's 16-bit pulse counters. The stimulus changes inputs only on the falling clock edge and issues far fewer than 65k enables. Apart from the deliberate in-flight write for R7, it programs taps only after the pipeline has fully drained. This keeps the bench's model of the active latency unambiguous.

// File: rtl/rden_delay_pkg.sv
package rden_delay_pkg;

    typedef enum logic {
        CF_RUN  = 1'b0,
        CF_WAIT = 1'b1
    } cfg_state_e;

    typedef enum logic {
        SEL_STB = 1'b0,
        SEL_RD  = 1'b1
    } tap_sel_e;

endpackage

// File: rtl/rden_tap_line.sv
module rden_tap_line #(
    parameter int DEPTH = 32,
    parameter int DW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          din,
    input  logic [DW-1:0] tap,
    output logic          dout,
    output logic          busy
);

    logic [DEPTH-1:0] stage;

    // first stage captures the input; every later stage follows its neighbour
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage[0] <= 1'b0;
        end else begin
            stage[0] <= din;
        end
    end

    genvar g;
    generate
        for (g = 1; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage[g] <= 1'b0;
                end else begin
                    stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    always_comb begin
        dout = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (tap == DW'(i)) begin
                dout = stage[i];
            end
        end
    end

    // any bit anywhere in the line counts, so that a longer tap later
    // cannot re-expose a stale pulse
    assign busy = |stage;

endmodule

// File: rtl/rden_cfg_ctrl.sv
module rden_cfg_ctrl
    import rden_delay_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int DW      = 5,
    parameter int STB_DEF = 5,
    parameter int RD_DEF  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [DW-1:0] cfg_val,
    input  logic          quiet,
    output logic [DW-1:0] stb_tap,
    output logic [DW-1:0] rd_tap,
    output logic          pending
);

    localparam logic [DW-1:0] TAP_MAX = DW'(DEPTH - 1);

    cfg_state_e    state, state_nx;
    logic [DW-1:0] stb_pend, rd_pend;
    logic [DW-1:0] val_clamped;
    logic          do_apply;

    assign val_clamped = (int'(cfg_val) > DEPTH - 1) ? TAP_MAX : cfg_val;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CF_RUN;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        do_apply = 1'b0;
        unique case (state)
            CF_RUN: begin
                if (cfg_we) begin
                    state_nx = CF_WAIT;
                end
            end
            CF_WAIT: begin
                if (!cfg_we && quiet) begin
                    state_nx = CF_RUN;
                    do_apply = 1'b1;
                end
            end
            default: state_nx = CF_RUN;
        endcase
    end

    // registered outputs: pending copies and active taps
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_pend <= DW'(STB_DEF);
            rd_pend  <= DW'(RD_DEF);
            stb_tap  <= DW'(STB_DEF);
            rd_tap   <= DW'(RD_DEF);
        end else begin
            if (cfg_we) begin
                if (tap_sel_e'(cfg_sel) == SEL_RD) begin
                    rd_pend <= val_clamped;
                end else begin
                    stb_pend <= val_clamped;
                end
            end
            if (do_apply) begin
                stb_tap <= stb_pend;
                rd_tap  <= rd_pend;
            end
        end
    end

    assign pending = (state == CF_WAIT);

endmodule

// File: rtl/rden_delay_gen.sv
module rden_delay_gen #(
    parameter int RD_LAT = 7,
    parameter int DEPTH  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en_in,
    input  logic                     cfg_we,
    input  logic                     cfg_sel,
    input  logic [$clog2(DEPTH)-1:0] cfg_val,
    output logic                     stb_gate_en,
    output logic                     fifo_rd_en,
    output logic                     rd_valid
);

    localparam int DW      = $clog2(DEPTH);
    localparam int RD_RAW  = (RD_LAT >= 1) ? RD_LAT - 1 : 0;
    localparam int STB_RAW = (RD_LAT >= 2) ? RD_LAT - 2 : 0;
    localparam int RD_DEF  = (RD_RAW  > DEPTH - 1) ? DEPTH - 1 : RD_RAW;
    localparam int STB_DEF = (STB_RAW > DEPTH - 1) ? DEPTH - 1 : STB_RAW;

    logic [DW-1:0] stb_tap, rd_tap;
    logic          stb_busy, rd_busy;
    logic          quiet;
    logic          cfg_pend;
    logic          rd_out;

    assign quiet = !stb_busy && !rd_busy && !rd_en_in;

    rden_cfg_ctrl #(
        .DEPTH   (DEPTH),
        .DW      (DW),
        .STB_DEF (STB_DEF),
        .RD_DEF  (RD_DEF)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_sel (cfg_sel),
        .cfg_val (cfg_val),
        .quiet   (quiet),
        .stb_tap (stb_tap),
        .rd_tap  (rd_tap),
        .pending (cfg_pend)
    );

    rden_tap_line #(.DEPTH(DEPTH), .DW(DW)) u_stb_line (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rd_en_in),
        .tap   (stb_tap),
        .dout  (stb_gate_en),
        .busy  (stb_busy)
    );

    rden_tap_line #(.DEPTH(DEPTH), .DW(DW)) u_rd_line (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rd_en_in),
        .tap   (rd_tap),
        .dout  (rd_out),
        .busy  (rd_busy)
    );

    assign fifo_rd_en = rd_out;
    assign rd_valid   = rd_out;

endmodule

// File: rtl/rden_delay_gen_chk.sv
module rden_delay_gen_chk #(
    parameter int DW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en_in,
    input logic          cfg_we,
    input logic          stb_gate_en,
    input logic          rd_valid,
    input logic          stb_busy,
    input logic          rd_busy,
    input logic          cfg_pend,
    input logic [DW-1:0] stb_tap,
    input logic [DW-1:0] rd_tap
);

    logic [15:0] in_cnt, rd_cnt, stb_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_cnt  <= '0;
            rd_cnt  <= '0;
            stb_cnt <= '0;
        end else begin
            in_cnt  <= in_cnt  + 16'(rd_en_in);
            rd_cnt  <= rd_cnt  + 16'(rd_valid);
            stb_cnt <= stb_cnt + 16'(stb_gate_en);
        end
    end

    // R7: active taps move only after a quiet cycle
    p_apply_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rd_tap) || !$stable(stb_tap)) |-> $past(!stb_busy && !rd_busy && !rd_en_in));

    // R7: a write always leaves a pending change behind it
    p_write_pends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_pend);

    // R5: a zero tap is a single register stage
    p_zero_tap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_tap == '0 && $past(rd_tap) == '0) |-> (rd_valid == $past(rd_en_in)));

    // R8: the read path never emits more pulses than it received
    p_rd_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= in_cnt);

    // R4: the strobe path never emits more pulses than it received
    p_stb_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_cnt <= in_cnt);

endmodule

bind rden_delay_gen rden_delay_gen_chk #(.DW($clog2(DEPTH))) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en_in    (rd_en_in),
    .cfg_we      (cfg_we),
    .stb_gate_en (stb_gate_en),
    .rd_valid    (rd_valid),
    .stb_busy    (stb_busy),
    .rd_busy     (rd_busy),
    .cfg_pend    (cfg_pend),
    .stb_tap     (stb_tap),
    .rd_tap      (rd_tap)
);

// File: tb/sim_rden_delay_gen.sv
module sim_rden_delay_gen;

    localparam int CLK_PERIOD = 10;
    localparam int RD_LAT     = 7;
    localparam int DEPTH      = 32;
    localparam int DW         = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en_in = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [DW-1:0] cfg_val = '0;
    logic          stb_gate_en, fifo_rd_en, rd_valid;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;
    int rd_d  = RD_LAT - 1;
    int stb_d = RD_LAT - 2;
    string rtag = "R3";
    string stag = "R4";
    int rq[$];
    int sq[$];

    rden_delay_gen #(.RD_LAT(RD_LAT), .DEPTH(DEPTH)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en_in    (rd_en_in),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_val     (cfg_val),
        .stb_gate_en (stb_gate_en),
        .fifo_rd_en  (fifo_rd_en),
        .rd_valid    (rd_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle=%0d actual=%0b expected=%0b", tag, cyc, act, exp);
        end
    endtask

    // driver: called at a falling edge, raises the enable for n cycles
    task automatic send(input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            rd_en_in = 1'b1;
            rq.push_back(cyc + 1 + rd_d);
            sq.push_back(cyc + 1 + stb_d);
            @(negedge clk);
        end
        rd_en_in = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic write_tap(input logic sel, input int val);
        cfg_we  = 1'b1;
        cfg_sel = sel;
        cfg_val = DW'(val);
        @(negedge clk);
        cfg_we  = 1'b0;
    endtask

    // program a tap with the pipeline drained, then update the model
    task automatic set_tap(input logic sel, input int val);
        wait (rq.size() == 0 && sq.size() == 0);
        @(negedge clk);
        repeat (DEPTH + 2) @(negedge clk);
        write_tap(sel, val);
        repeat (2) @(negedge clk);
        if (sel) rd_d = (val > DEPTH - 1) ? DEPTH - 1 : val;
        else     stb_d = (val > DEPTH - 1) ? DEPTH - 1 : val;
    endtask

    // monitor: scoreboard compare once per cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic er, es;
            er = (rq.size() > 0 && rq[0] == cyc);
            es = (sq.size() > 0 && sq[0] == cyc);
            if (er) void'(rq.pop_front());
            if (es) void'(sq.pop_front());
            check(rd_valid, er, rtag);
            check(stb_gate_en, es, stag);
            check(fifo_rd_en, rd_valid, "R2");
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog cycle=%0d actual=running expected=finished", cyc);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs low in reset
        check(rd_valid, 1'b0, "R1");
        check(stb_gate_en, 1'b0, "R1");
        check(fifo_rd_en, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3 R4: default taps, single pulse and a burst (R8)
        rtag = "R3"; stag = "R4";
        send(1, 12);
        rtag = "R8"; stag = "R8";
        send(5, 3);
        send(2, 1);
        send(1, 15);

        // R5: zero taps on both paths
        rtag = "R5"; stag = "R5";
        set_tap(1'b0, 0);
        set_tap(1'b1, 0);
        send(3, 2);
        send(1, 1);
        send(1, 5);

        // R6: write the read tap only, strobe keeps zero
        rtag = "R6"; stag = "R6";
        set_tap(1'b1, 4);
        send(2, 10);

        // R9: largest read tap, strobe addressed separately
        rtag = "R9"; stag = "R9";
        set_tap(1'b1, 31);
        set_tap(1'b0, 3);
        send(4, 40);

        // R7: write while enables are in flight, more enables follow
        rtag = "R7"; stag = "R7";
        set_tap(1'b1, 10);
        send(3, 0);
        write_tap(1'b1, 2);
        send(2, 0);
        wait (rq.size() == 0 && sq.size() == 0);
        @(negedge clk);
        repeat (DEPTH + 2) @(negedge clk);
        rd_d = 2;
        send(3, 2);
        send(1, 8);

        // R8: mixed gaps with new taps
        rtag = "R8"; stag = "R8";
        set_tap(1'b0, 1);
        send(6, 1);
        send(1, 0);
        send(2, 3);
        send(7, 20);

        wait (rq.size() == 0 && sq.size() == 0);
        repeat (DEPTH + 2) @(negedge clk);
        total++;
        if (rq.size() != 0 || sq.size() != 0) begin
            bad++;
            $display("FAIL R8 leftover actual=%0d expected=0", rq.size() + sq.size());
        end
        finish_run();
    end

endmodule